// File: doc/BRIEF.md
# Regulator Fault Detection Sequencer

This block watches one regulator channel together with the device-wide fault inputs. Its inputs are already synchronized digital levels: the channel enable, a current-limit comparator, an output-below-threshold comparator, a power-good comparator, a thermal-shutdown flag and a supply-overvoltage flag. It applies debounce and timing windows to these inputs. Its outputs are single-cycle event pulses for an interrupt controller, a regulator-disable command and a force-low command for the general-purpose outputs.

The output-below-threshold comparator is read in two ways. It is sampled once, exactly one millisecond after enable, as a short-circuit check. After that it acts as an overload detector with a one-millisecond debounce. Either result shuts the channel off and holds it off until the enable is taken away and applied again. Thermal shutdown and overvoltage override every other path. The timebase is set by a parameter giving the number of clock cycles per microsecond.

Top module: `reg_fault_seq`

## Requirements
- R1: While `rstN` is low and at the first falling clock edge after it rises, all event outputs are 0, `gpioLow` is 0 and `regDisable` is 1 (sequencer off).
- R2: With the channel on (`regDisable` = 0), `ilimEvt` pulses in the cycle after the edge that samples `ilimIn` high for the N-th consecutive time, where N = ILIM_US*CYC_PER_US. Shorter runs raise no event.
- R3: A rising `regEn` seen in the off state starts a check window. At the edge M = SC_US*CYC_PER_US edges after the one that accepted the enable, `lowOutIn` is sampled once. If it is high, `scEvt` pulses and the channel is disabled. If it is low, the channel stays on and runs.
- R4: While running, if `lowOutIn` is sampled high on M consecutive edges, `scEvt` pulses after the M-th edge.
- R5: Whenever `scEvt` pulses, `regDisable` is 1 in that same cycle.
- R6: `pgEvt` pulses one cycle after a rising edge of `pgIn` that is sampled while the channel is on. A rising edge while the channel is off gives no pulse.
- R7: After a fault, `regDisable` stays 1 for as long as `regEn` stays high. Only a fall followed by a new rise of `regEn` restarts the channel.
- R8: Every debounce count restarts from zero when its input is sampled low. Each event output is high for exactly one cycle per confirmed condition.
- R9: The edge that samples `tsdIn` or `ovpIn` high drives `regDisable` and `gpioLow` to 1. `gpioLow` follows the level of the two faults, delayed by one edge. A rising edge of `tsdIn` pulses `tsdEvt`, and a rising edge of `ovpIn` pulses `ovpEvt`.
- R10: Thermal shutdown and overvoltage move the sequencer to the fault state from any state, including the startup window and the off state. They hold it there while active, whatever `regEn` does, and they suppress any short-circuit result on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regEn | input | 1 | Channel enable request |
| ilimIn | input | 1 | Current-limit comparator |
| lowOutIn | input | 1 | Output below short-circuit threshold |
| pgIn | input | 1 | Output at programmed level |
| tsdIn | input | 1 | Die over-temperature shutdown |
| ovpIn | input | 1 | Supply overvoltage |
| ilimEvt | output | 1 | Current-limit event pulse |
| scEvt | output | 1 | Short-circuit / overload event pulse |
| pgEvt | output | 1 | Power-good event pulse |
| tsdEvt | output | 1 | Thermal-shutdown event pulse |
| ovpEvt | output | 1 | Overvoltage event pulse |
| regDisable | output | 1 | Regulator disable command |
| gpioLow | output | 1 | Force general-purpose outputs low |

## Verification
Every result is registered, so each is due exactly one clock edge after the edge that confirms it. The current-limit pulse follows the N-th consecutive high edge. The startup verdict follows the M-th edge after the enable is accepted, the overload pulse follows the M-th consecutive low-output edge, and the power-good, thermal and overvoltage results follow the first edge that samples the new level. The bench changes inputs on falling edges and counts rising edges from there. It reads outputs on the falling edge where the result is due and on the falling edge just before it, so a result that arrives one cycle early or one cycle late is caught.

// File: rtl/reg_fault_pkg.sv
package reg_fault_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_STARTUP = 2'd1,
    ST_RUN     = 2'd2,
    ST_FAULT   = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic chanOn;
    logic startTmrEn;
    logic ovldEn;
  } ctlStrobe_t;

  // flags from datapath to control
  typedef struct packed {
    logic startDone;
    logic ovldHit;
  } dpFlag_t;

endpackage

// File: rtl/reg_fault_dp.sv
module reg_fault_dp
  import reg_fault_pkg::*;
#(
  parameter int CYC_PER_US = 4,
  parameter int ILIM_US    = 20,
  parameter int SC_US      = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  input  logic       ilimIn,
  input  logic       lowOutIn,
  input  logic       pgIn,
  input  logic       tsdIn,
  input  logic       ovpIn,
  output dpFlag_t    flags,
  output logic       ilimEvt,
  output logic       pgEvt,
  output logic       tsdEvt,
  output logic       ovpEvt,
  output logic       gpioLow
);

  localparam int ILIM_CYC = ILIM_US * CYC_PER_US;
  localparam int SC_CYC   = SC_US * CYC_PER_US;
  localparam int ILIM_W   = $clog2(ILIM_CYC + 1);
  localparam int SC_W     = $clog2(SC_CYC + 1);
  localparam int N_EDGE   = 3;

  logic [ILIM_W-1:0] ilimCnt;
  logic [SC_W-1:0]   startTmr;
  logic [SC_W-1:0]   ovldCnt;

  // current-limit debounce, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ilimCnt <= '0;
      ilimEvt <= 1'b0;
    end else begin
      ilimEvt <= ctl.chanOn && ilimIn && (ilimCnt == ILIM_W'(ILIM_CYC - 1));
      if (!ctl.chanOn || !ilimIn)
        ilimCnt <= '0;
      else if (ilimCnt != ILIM_W'(ILIM_CYC))
        ilimCnt <= ilimCnt + ILIM_W'(1);
    end
  end

  // startup window timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               startTmr <= '0;
    else if (!ctl.startTmrEn) startTmr <= '0;
    else if (startTmr != SC_W'(SC_CYC - 1))
      startTmr <= startTmr + SC_W'(1);
  end

  // overload debounce while running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        ovldCnt <= '0;
    else if (!ctl.ovldEn || !lowOutIn) ovldCnt <= '0;
    else if (ovldCnt != SC_W'(SC_CYC - 1))
      ovldCnt <= ovldCnt + SC_W'(1);
  end

  assign flags.startDone = ctl.startTmrEn && (startTmr == SC_W'(SC_CYC - 1));
  assign flags.ovldHit   = ctl.ovldEn && lowOutIn && (ovldCnt == SC_W'(SC_CYC - 1));

  // rising-edge detectors: index 0 power good, 1 thermal, 2 overvoltage
  logic [N_EDGE-1:0] edgeIn;
  logic [N_EDGE-1:0] edgePrev;
  logic [N_EDGE-1:0] edgeQual;
  logic [N_EDGE-1:0] edgePulse;

  assign edgeIn   = {ovpIn, tsdIn, pgIn};
  assign edgeQual = {1'b1, 1'b1, ctl.chanOn};

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        edgePrev[g]  <= 1'b0;
        edgePulse[g] <= 1'b0;
      end else begin
        edgePrev[g]  <= edgeIn[g];
        edgePulse[g] <= edgeIn[g] && !edgePrev[g] && edgeQual[g];
      end
    end
  end

  assign pgEvt  = edgePulse[0];
  assign tsdEvt = edgePulse[1];
  assign ovpEvt = edgePulse[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gpioLow <= 1'b0;
    else       gpioLow <= tsdIn || ovpIn;
  end

endmodule

// File: rtl/reg_fault_ctrl.sv
module reg_fault_ctrl
  import reg_fault_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regEn,
  input  logic       lowOutIn,
  input  logic       devFault,
  input  dpFlag_t    flags,
  output ctlStrobe_t ctl,
  output logic       scEvt,
  output seqState_t  stateQ
);

  seqState_t stateD;
  logic      scD;

  always_comb begin
    stateD = stateQ;
    scD    = 1'b0;
    if (devFault) begin
      stateD = ST_FAULT;
    end else begin
      unique case (stateQ)
        ST_OFF:     if (regEn) stateD = ST_STARTUP;
        ST_STARTUP: begin
          if (!regEn) stateD = ST_OFF;
          else if (flags.startDone) begin
            if (lowOutIn) begin
              stateD = ST_FAULT;
              scD    = 1'b1;
            end else begin
              stateD = ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (!regEn) stateD = ST_OFF;
          else if (flags.ovldHit) begin
            stateD = ST_FAULT;
            scD    = 1'b1;
          end
        end
        ST_FAULT:   if (!regEn) stateD = ST_OFF;
        default:    stateD = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_OFF;
      scEvt  <= 1'b0;
    end else begin
      stateQ <= stateD;
      scEvt  <= scD;
    end
  end

  assign ctl.chanOn     = (stateQ == ST_STARTUP) || (stateQ == ST_RUN);
  assign ctl.startTmrEn = (stateQ == ST_STARTUP);
  assign ctl.ovldEn     = (stateQ == ST_RUN);

endmodule

// File: rtl/reg_fault_seq.sv
module reg_fault_seq
  import reg_fault_pkg::*;
#(
  parameter int CYC_PER_US = 4,
  parameter int ILIM_US    = 20,
  parameter int SC_US      = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic regEn,
  input  logic ilimIn,
  input  logic lowOutIn,
  input  logic pgIn,
  input  logic tsdIn,
  input  logic ovpIn,
  output logic ilimEvt,
  output logic scEvt,
  output logic pgEvt,
  output logic tsdEvt,
  output logic ovpEvt,
  output logic regDisable,
  output logic gpioLow
);

  ctlStrobe_t ctl;
  dpFlag_t    flags;
  seqState_t  stateQ;
  logic       devFault;

  assign devFault = tsdIn || ovpIn;

  reg_fault_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regEn    (regEn),
    .lowOutIn (lowOutIn),
    .devFault (devFault),
    .flags    (flags),
    .ctl      (ctl),
    .scEvt    (scEvt),
    .stateQ   (stateQ)
  );

  reg_fault_dp #(
    .CYC_PER_US (CYC_PER_US),
    .ILIM_US    (ILIM_US),
    .SC_US      (SC_US)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .ilimIn   (ilimIn),
    .lowOutIn (lowOutIn),
    .pgIn     (pgIn),
    .tsdIn    (tsdIn),
    .ovpIn    (ovpIn),
    .flags    (flags),
    .ilimEvt  (ilimEvt),
    .pgEvt    (pgEvt),
    .tsdEvt   (tsdEvt),
    .ovpEvt   (ovpEvt),
    .gpioLow  (gpioLow)
  );

  assign regDisable = !ctl.chanOn;

endmodule

// File: rtl/reg_fault_chk.sv
module reg_fault_chk
  import reg_fault_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      regEn,
  input logic      ilimIn,
  input logic      pgIn,
  input logic      tsdIn,
  input logic      ovpIn,
  input logic      ilimEvt,
  input logic      scEvt,
  input logic      pgEvt,
  input logic      tsdEvt,
  input logic      ovpEvt,
  input logic      regDisable,
  input logic      gpioLow,
  input seqState_t stateQ
);

  assert_sc_disables_R5: assert property (@(posedge clk) disable iff (!rstN)
    scEvt |-> regDisable);

  assert_fault_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_FAULT && regEn) |=> regDisable);

  assert_dev_fault_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tsdIn || ovpIn) |=> (regDisable && gpioLow));

  assert_ilim_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    ilimEvt |-> $past(ilimIn));

  assert_pg_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    pgEvt |-> ($past(pgIn) && !$past(pgIn, 2)));

  assert_ilim_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    ilimEvt |=> !ilimEvt);

  assert_sc_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    scEvt |=> !scEvt);

  assert_tsd_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    tsdEvt |=> !tsdEvt);

  assert_ovp_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    ovpEvt |=> !ovpEvt);

endmodule

bind reg_fault_seq reg_fault_chk u_chk (.*);

// File: tb/reg_fault_seq_tb.sv
module reg_fault_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;
  localparam int N_ILIM     = 20 * CPU;
  localparam int M_SC       = 1000 * CPU;
  localparam int N_VEC      = 6;
  localparam int VEC_LEN [N_VEC] = '{1, N_ILIM - 1, N_ILIM, N_ILIM + 7, 5, 2 * N_ILIM};
  localparam int VEC_EXP [N_VEC] = '{0, 0, 1, 1, 0, 1};

  logic clk = 1'b0;
  logic rstN, regEn, ilimIn, lowOutIn, pgIn, tsdIn, ovpIn;
  logic ilimEvt, scEvt, pgEvt, tsdEvt, ovpEvt, regDisable, gpioLow;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  reg_fault_seq #(.CYC_PER_US(CPU), .ILIM_US(20), .SC_US(1000)) u_dut (
    .clk(clk), .rstN(rstN), .regEn(regEn), .ilimIn(ilimIn), .lowOutIn(lowOutIn),
    .pgIn(pgIn), .tsdIn(tsdIn), .ovpIn(ovpIn), .ilimEvt(ilimEvt), .scEvt(scEvt),
    .pgEvt(pgEvt), .tsdEvt(tsdEvt), .ovpEvt(ovpEvt), .regDisable(regDisable),
    .gpioLow(gpioLow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int cnt;
    int firstAt;
    rstN = 0; regEn = 0; ilimIn = 0; lowOutIn = 0; pgIn = 0; tsdIn = 0; ovpIn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 regDisable", regDisable, 1);
    chk("R1 events", {ilimEvt, scEvt, pgEvt, tsdEvt, ovpEvt}, 0);
    chk("R1 gpioLow", gpioLow, 0);

    // R3 startup with good output
    regEn = 1;
    cyc(1);
    chk("R3 startup on", regDisable, 0);
    cyc(M_SC - 1);
    chk("R3 before check", scEvt, 0);
    cyc(1);
    chk("R3 good output no sc", scEvt, 0);
    chk("R3 running", regDisable, 0);

    // R2/R8 current-limit vectors
    for (int i = 0; i < N_VEC; i++) begin
      cnt = 0; firstAt = 0;
      ilimIn = 1;
      for (int k = 1; k <= VEC_LEN[i]; k++) begin
        cyc(1);
        if (ilimEvt) begin
          cnt++;
          if (firstAt == 0) firstAt = k;
        end
      end
      ilimIn = 0;
      for (int k = 0; k < 3; k++) begin
        cyc(1);
        if (ilimEvt) cnt++;
      end
      chk("R2 R8 ilim event count", cnt, VEC_EXP[i]);
      if (VEC_EXP[i] == 1) chk("R2 ilim timing", firstAt, N_ILIM);
    end

    // R6 power good while on
    pgIn = 1;
    cyc(1);
    chk("R6 pg pulse", pgEvt, 1);
    cyc(1);
    chk("R6 R8 pg single", pgEvt, 0);
    pgIn = 0;
    cyc(1);

    // R4/R8 overload one cycle short
    cnt = 0;
    lowOutIn = 1;
    for (int k = 0; k < M_SC - 1; k++) begin
      cyc(1);
      if (scEvt) cnt++;
    end
    lowOutIn = 0;
    cyc(1);
    if (scEvt) cnt++;
    chk("R4 R8 short overload no event", cnt, 0);
    chk("R4 still running", regDisable, 0);

    // R4/R5 full overload
    lowOutIn = 1;
    cyc(M_SC - 1);
    chk("R4 before overload", scEvt, 0);
    cyc(1);
    chk("R4 overload event", scEvt, 1);
    chk("R5 disabled with sc", regDisable, 1);
    lowOutIn = 0;
    cyc(1);
    chk("R8 sc single", scEvt, 0);

    // R7 sticky fault
    cyc(50);
    chk("R7 held off", regDisable, 1);
    pgIn = 1;
    cyc(1);
    chk("R6 pg ignored while off", pgEvt, 0);
    pgIn = 0;
    regEn = 0;
    cyc(1);
    chk("R7 off", regDisable, 1);

    // R3 short circuit at startup
    lowOutIn = 1;
    regEn = 1;
    cyc(1);
    chk("R7 restart", regDisable, 0);
    cyc(M_SC - 1);
    chk("R3 before check sc", scEvt, 0);
    cyc(1);
    chk("R3 sc at startup", scEvt, 1);
    chk("R3 R5 disabled", regDisable, 1);
    lowOutIn = 0;

    // R9/R10 thermal shutdown in run
    regEn = 0;
    cyc(1);
    regEn = 1;
    cyc(M_SC + 1);
    chk("R3 run again", regDisable, 0);
    tsdIn = 1;
    cyc(1);
    chk("R9 tsd event", tsdEvt, 1);
    chk("R9 tsd disable", regDisable, 1);
    chk("R9 gpio low", gpioLow, 1);
    regEn = 0;
    cyc(1);
    regEn = 1;
    cyc(5);
    chk("R10 held by tsd", regDisable, 1);
    chk("R9 gpio held", gpioLow, 1);
    chk("R8 tsd single", tsdEvt, 0);
    tsdIn = 0;
    regEn = 0;
    cyc(1);
    chk("R9 gpio release", gpioLow, 0);

    // R10 overvoltage during startup window
    regEn = 1;
    cyc(100);
    chk("R10 in startup", regDisable, 0);
    ovpIn = 1;
    lowOutIn = 1;
    cyc(1);
    chk("R9 ovp event", ovpEvt, 1);
    chk("R10 ovp disable", regDisable, 1);
    ovpIn = 0;
    cnt = 0;
    for (int k = 0; k < M_SC; k++) begin
      cyc(1);
      if (scEvt) cnt++;
    end
    chk("R10 no sc after ovp", cnt, 0);
    chk("R7 stays off after ovp", regDisable, 1);
    lowOutIn = 0;

    finish_run();
  end

endmodule